// File: doc/BRIEF.md
# Temporal Fence Flush Sequencer

This block sits beside the commit stage of an in-order core. When a committed instruction is a temporal fence, it reads the fence's select bitmap and raises a flush request to each microarchitectural unit the bitmap names. The units are the pipeline, both L1 caches, the TLB, the branch-history counters, the branch-target buffer, the replacement LFSRs, the data-cache port arbiter and the TLB pseudo-LRU tree. Resetting secondary state such as replacement and arbitration pointers, and not only valid bits, is what lets the fence separate the timing of later code from what ran before.

While any selected unit is still busy, the block holds commit stalled. Each unit answers on its own done line, and latencies differ: register-sized state clears in one cycle, while data-cache invalidation walks its sets for hundreds of cycles. The block remembers which selected units have answered. Once the last of them has answered, it releases the stall and pulses a completion strobe for one cycle. Units that were not selected get no request, and their done lines play no part.

Top module: `tfence_flush`

## Requirements
- R1: A fence is recognised only when `commitValid` is high, bits 6:0 of `commitInsn` equal 7'b0001011, and bits 11:7 are all zero. Any other committed word produces no request, no stall and no completion.
- R2: The select bitmap is `commitInsn[31:12]`. Bitmap bit k drives `flushReq[k]`: 0 pipeline, 1 I-cache, 2 D-cache, 3 TLB, 4 branch-history counters, 5 branch-target buffer, 6 replacement LFSRs, 7 data-cache arbiter, 8 TLB PLRU tree. In the cycle after the commit, `flushReq` equals bitmap bits 8:0 for exactly one cycle.
- R3: Bitmap bits 19:9 (instruction bits 31:21) are reserved and have no effect on requests or completion.
- R4: For a non-zero selection, `commitStall` is high from the cycle after the commit until the last selected done has been sampled, however long that takes.
- R5: `fenceComplete` is high for one cycle, in the cycle after the clock edge that samples the last outstanding selected done. `commitStall` is low in that cycle.
- R6: With bits 8:0 of the bitmap all zero, `fenceComplete` is high in the cycle after the commit, `commitStall` stays low and no request is raised.
- R7: Each selected unit's done is remembered once it has been sampled, so done pulses may arrive at different cycles. Done lines of unselected units do not affect completion.
- R8: A fence committed while `commitStall` is high is ignored. It raises no request and does not change the set of outstanding units.
- R9: After reset, `flushReq` is zero and `commitStall` and `fenceComplete` are low.
- R10: Done lines that are asserted while no fence is outstanding do not count toward a later fence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| commitValid | input | 1 | The instruction on `commitInsn` commits this cycle |
| commitInsn | input | 32 | Committed instruction word |
| flushDone | input | 9 | Per-unit flush finished, same bit order as `flushReq` |
| flushReq | output | 9 | Per-unit one-cycle flush request |
| commitStall | output | 1 | Hold further commits |
| fenceComplete | output | 1 | One-cycle pulse when the fence has finished |

## Verification
Every result is registered once. Requests and the rise of the stall are due in the cycle after the committing edge. Completion and the fall of the stall are due in the cycle after the edge that samples the last selected done, and a zero selection completes in the cycle after the commit. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so each check lands in the cycle those counts give. The long-latency case holds the stall for 256 cycles and checks it in every one of them. The staggered case checks that the stall is still high after each partial done.

// File: rtl/tfence_pkg.sv
package tfence_pkg;

  localparam logic [6:0] FENCE_OPCODE = 7'b0001011;
  localparam int         INSN_W       = 32;
  localparam int         SEL_LSB      = 12;
  localparam int         SEL_W        = 20;
  localparam int         RD_LSB       = 7;
  localparam int         RD_W         = 5;

  // bit positions inside the select bitmap
  localparam int UNIT_PIPE  = 0;
  localparam int UNIT_ICACHE = 1;
  localparam int UNIT_DCACHE = 2;
  localparam int UNIT_TLB   = 3;
  localparam int UNIT_BHT   = 4;
  localparam int UNIT_BTB   = 5;
  localparam int UNIT_LFSR  = 6;
  localparam int UNIT_ARB   = 7;
  localparam int UNIT_PLRU  = 8;
  localparam int UNIT_COUNT = 9;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
  } ctrlStrobeT;

  // datapath -> control status
  typedef struct packed {
    logic hit;
    logic selEmpty;
    logic allDone;
  } dpStatusT;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } fenceStateT;

endpackage

// File: rtl/tfence_decode.sv
module tfence_decode
  import tfence_pkg::*;
#(
  parameter int NUM_UNITS = UNIT_COUNT
) (
  input  logic                 commitValid,
  input  logic [INSN_W-1:0]    commitInsn,
  output logic                 fenceHit,
  output logic [NUM_UNITS-1:0] unitSel
);

  localparam int SEL_TOP = SEL_LSB + NUM_UNITS;

  logic opMatch;
  logic rdZero;

  assign opMatch  = (commitInsn[6:0] == FENCE_OPCODE);
  assign rdZero   = (commitInsn[RD_LSB +: RD_W] == '0);
  assign fenceHit = commitValid && opMatch && rdZero;
  assign unitSel  = commitInsn[SEL_LSB +: NUM_UNITS];

  // reserved bitmap bits above the implemented units are dropped (R3)
  generate
    if (SEL_TOP < INSN_W) begin : g_reserved
      logic unusedReserved;
      assign unusedReserved = ^commitInsn[INSN_W-1:SEL_TOP];
    end
  endgenerate

  always_comb begin
    if (NUM_UNITS > SEL_W) $error("NUM_UNITS exceeds bitmap width");
  end

endmodule

// File: rtl/tfence_datapath.sv
module tfence_datapath
  import tfence_pkg::*;
#(
  parameter int NUM_UNITS = UNIT_COUNT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 commitValid,
  input  logic [INSN_W-1:0]    commitInsn,
  input  logic [NUM_UNITS-1:0] flushDone,
  input  ctrlStrobeT           strobe,
  output dpStatusT             status,
  output logic [NUM_UNITS-1:0] flushReq
);

  logic                 fenceHit;
  logic [NUM_UNITS-1:0] unitSel;
  logic [NUM_UNITS-1:0] pendQ;
  logic [NUM_UNITS-1:0] reqQ;

  tfence_decode #(.NUM_UNITS(NUM_UNITS)) i_decode (
    .commitValid (commitValid),
    .commitInsn  (commitInsn),
    .fenceHit    (fenceHit),
    .unitSel     (unitSel)
  );

  // one pending flag and one request flop per unit
  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pendQ[u] <= 1'b0;
          reqQ[u]  <= 1'b0;
        end else begin
          reqQ[u] <= strobe.load && unitSel[u];
          if (strobe.load) begin
            pendQ[u] <= unitSel[u];
          end else if (flushDone[u]) begin
            pendQ[u] <= 1'b0;
          end
        end
      end
    end
  endgenerate

  assign flushReq        = reqQ;
  assign status.hit      = fenceHit;
  assign status.selEmpty = (unitSel == '0);
  assign status.allDone  = ((pendQ & ~flushDone) == '0);

  // requests only go to units still waiting on a flush
  AST_REQ_WITHIN_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq & ~pendQ) == '0);                                        // R2

  // a request is only ever the echo of a load on the previous edge
  AST_REQ_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (|flushReq) |-> $past(strobe.load));                               // R2

  // without a new load the outstanding set never gains members
  AST_PEND_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ((pendQ & ~$past(pendQ)) == '0));                 // R7

endmodule

// File: rtl/tfence_ctrl.sv
module tfence_ctrl
  import tfence_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatusT   status,
  output ctrlStrobeT strobe,
  output logic       commitStall,
  output logic       fenceComplete
);

  fenceStateT stateQ, stateD;
  logic       completeQ, completeD;

  always_comb begin
    stateD      = stateQ;
    completeD   = 1'b0;
    strobe.load = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (status.hit) begin
          strobe.load = 1'b1;
          if (status.selEmpty) begin
            completeD = 1'b1;
          end else begin
            stateD = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (status.allDone) begin
          completeD = 1'b1;
          stateD    = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      completeQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      completeQ <= completeD;
    end
  end

  assign commitStall   = (stateQ == ST_WAIT);
  assign fenceComplete = completeQ;

  // completion never overlaps the stall
  AST_COMPLETE_UNSTALLED: assert property (@(posedge clk) disable iff (!rstN)
    fenceComplete |-> !commitStall);                                   // R5

  // the stall is only released through a completion
  AST_RELEASE_COMPLETES: assert property (@(posedge clk) disable iff (!rstN)
    $fell(commitStall) |-> fenceComplete);                             // R5

  // the stall only starts from a recognised fence
  AST_STALL_FROM_FENCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(commitStall) |-> $past(status.hit));                         // R4

endmodule

// File: rtl/tfence_flush.sv
module tfence_flush
  import tfence_pkg::*;
#(
  parameter int NUM_UNITS = UNIT_COUNT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 commitValid,
  input  logic [INSN_W-1:0]    commitInsn,
  input  logic [NUM_UNITS-1:0] flushDone,
  output logic [NUM_UNITS-1:0] flushReq,
  output logic                 commitStall,
  output logic                 fenceComplete
);

  ctrlStrobeT strobe;
  dpStatusT   status;

  tfence_datapath #(.NUM_UNITS(NUM_UNITS)) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .commitValid (commitValid),
    .commitInsn  (commitInsn),
    .flushDone   (flushDone),
    .strobe      (strobe),
    .status      (status),
    .flushReq    (flushReq)
  );

  tfence_ctrl i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .status        (status),
    .strobe        (strobe),
    .commitStall   (commitStall),
    .fenceComplete (fenceComplete)
  );

  // a request is raised only while commit is held
  AST_REQ_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    (|flushReq) |-> commitStall);                                      // R4

  // no request is repeated on consecutive stalled cycles
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rstN)
    (commitStall && $past(commitStall)) |-> (flushReq == '0));         // R8

endmodule

// File: tb/test_tfence_flush.sv
`timescale 1ns/1ps
module test_tfence_flush;

  localparam int NU = 9;
  localparam int NV = 8;
  localparam int WATCHDOG_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          commitValid = 1'b0;
  logic [31:0]   commitInsn = '0;
  logic [NU-1:0] flushDone = '0;
  logic [NU-1:0] flushReq;
  logic          commitStall;
  logic          fenceComplete;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tfence_flush i_tfence_flush (
    .clk           (clk),
    .rstN          (rstN),
    .commitValid   (commitValid),
    .commitInsn    (commitInsn),
    .flushDone     (flushDone),
    .flushReq      (flushReq),
    .commitStall   (commitStall),
    .fenceComplete (fenceComplete)
  );

  // {instruction, expected request mask, completion expected}
  localparam logic [41:0] VECS [NV] = '{
    {32'h0000100B, 9'h001, 1'b1},   // pipeline only
    {32'h001FF00B, 9'h1FF, 1'b1},   // every unit
    {32'h0010400B, 9'h104, 1'b1},   // D-cache and PLRU
    {32'hFFE0A00B, 9'h00A, 1'b1},   // reserved bits set
    {32'h001FF00F, 9'h000, 1'b0},   // other opcode
    {32'h001FF08B, 9'h000, 1'b0},   // bits 11:7 non-zero
    {32'h0000000B, 9'h000, 1'b1},   // empty selection
    {32'h000C000B, 9'h0C0, 1'b1}    // LFSR and arbiter
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic commitOne(input logic [31:0] insn);
    commitValid = 1'b1;
    commitInsn  = insn;
    @(negedge clk);
    commitValid = 1'b0;
    commitInsn  = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 req", 32'(flushReq), 0);
    chk("R9 stall", 32'(commitStall), 0);
    chk("R9 complete", 32'(fenceComplete), 0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R3 R5 R6
    for (int v = 0; v < NV; v++) begin
      logic [31:0]   insn;
      logic [NU-1:0] mask;
      logic          doneExp;
      insn    = VECS[v][41:10];
      mask    = VECS[v][9:1];
      doneExp = VECS[v][0];
      commitOne(insn);
      chk("R2 request mask", 32'(flushReq), 32'(mask));
      chk("R4 stall rise", 32'(commitStall), 32'(mask != 0));
      if (mask == 0) begin
        chk("R6/R1 early complete", 32'(fenceComplete), 32'(doneExp));
      end else begin
        chk("R5 complete low while busy", 32'(fenceComplete), 0);
        flushDone = mask;
        @(negedge clk);
        flushDone = '0;
        chk("R5 complete pulse", 32'(fenceComplete), 1);
        chk("R5 stall released", 32'(commitStall), 0);
        chk("R2 request one cycle", 32'(flushReq), 0);
      end
      @(negedge clk);
      chk("R5 single pulse", 32'(fenceComplete), 0);
      chk("R1 no stall", 32'(commitStall), 0);
    end

    // R7 staggered dones with an unselected done mixed in
    commitOne(32'h0010600B);       // I-cache, D-cache, PLRU
    chk("R7 req", 32'(flushReq), 32'h106);
    flushDone = 9'h003;            // pipeline (unselected) + I-cache
    @(negedge clk);
    chk("R7 stall after partial", 32'(commitStall), 1);
    chk("R7 no complete", 32'(fenceComplete), 0);
    flushDone = 9'h000;
    // R4 long D-cache walk
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      if (commitStall !== 1'b1 || fenceComplete !== 1'b0) begin
        chk("R4 stall held during walk", {31'b0, commitStall}, 1);
      end
    end
    nChecks++;
    flushDone = 9'h004;
    @(negedge clk);
    flushDone = 9'h000;
    chk("R7 waits for PLRU", 32'(commitStall), 1);
    @(negedge clk);
    chk("R7 still waiting", 32'(fenceComplete), 0);
    flushDone = 9'h100;
    @(negedge clk);
    flushDone = 9'h000;
    chk("R7 complete after slowest", 32'(fenceComplete), 1);
    chk("R7 stall low", 32'(commitStall), 0);
    @(negedge clk);

    // R8 fence committed while stalled
    commitOne(32'h0000400B);       // D-cache
    chk("R8 first req", 32'(flushReq), 32'h004);
    commitOne(32'h0000100B);       // pipeline, while stalled
    chk("R8 ignored req", 32'(flushReq), 0);
    flushDone = 9'h001;
    @(negedge clk);
    flushDone = 9'h000;
    chk("R8 set unchanged", 32'(commitStall), 1);
    flushDone = 9'h004;
    @(negedge clk);
    flushDone = 9'h000;
    chk("R8 complete", 32'(fenceComplete), 1);
    @(negedge clk);

    // R10 idle dones do not carry over
    flushDone = 9'h1FF;
    repeat (3) @(negedge clk);
    flushDone = 9'h000;
    commitOne(32'h0001000B);       // BHT counters
    chk("R10 req", 32'(flushReq), 32'h010);
    @(negedge clk);
    chk("R10 still stalled", 32'(commitStall), 1);
    chk("R10 not complete", 32'(fenceComplete), 0);
    flushDone = 9'h010;
    @(negedge clk);
    flushDone = 9'h000;
    chk("R10 complete", 32'(fenceComplete), 1);

    @(negedge clk);
    finish_run();
  end

endmodule